// File: doc/BRIEF.md
# Windowed Watchdog Timer with Clock-Domain Synchronizer

This block is a watchdog timer. Its counter runs on a slow, free-running timeout clock. It is configured through three byte-wide registers that sit in the faster bus clock domain. Software has to refresh the watchdog before the timeout runs out. If it does not, the block raises a reset request for one timeout-clock cycle.

In window mode the timeout has two parts: a closed period followed by an open period. A refresh that arrives during the closed period counts as a fault and raises the reset request at once. A refresh that arrives during the open period restarts the count.

Configuration writes are only accepted while the change-protection unlock input is high. A write that must reach the timeout domain is carried over by a toggle handshake. A busy flag in the status register stays set until that handshake returns, and any write made while it is set is dropped. Changing the window settings also requires a change-enable bit to be written high in the same write.

Top module: `wwdt_core`

## Requirements
- R1: After reset every readback (addresses 0 to 3) is zero and `rst_req` is low.
- R2: A write while `unlock` is low changes nothing in any register.
- R3: The window register (address 1) holds the window enable at bit 1 and the closed-period code at bits 5:2. These fields update only when bit 0 of the same written byte is one; otherwise the write is ignored. Bit 0 always reads zero.
- R4: The control register (address 0) holds the enable at bit 0 and the timeout (open-period) code at bits 5:2. All other bits read zero.
- R5: The status register (address 2) bit 0 is the busy flag. An accepted control or window write sets it if the enable bit is one before or after the write. It clears by itself once the timeout domain has taken the new settings. A write that leaves the enable at zero both before and after never sets it.
- R6: Status bits 7:1 and every bit at address 3 read zero, and writes to those addresses have no effect.
- R7: Any write made while the busy flag is set is ignored.
- R8: A period code c maps to cycles as follows:
  - codes 6 to 10 give BASE_CYC·2^(c−6) timeout-clock cycles;
  - codes 11 to 15 give the same length as code 10;
  - codes 0 to 5 give BASE_CYC/2^(6−c), with a minimum of one cycle.
- R9: In normal mode an enabled watchdog raises `rst_req` for one timeout-clock cycle if no refresh arrives within the open-period length after the last restart. A refresh restarts the count.
- R10: In window mode a refresh before the closed-period count has elapsed raises `rst_req` and restarts the count. A refresh after it restarts the count only. With no refresh, `rst_req` is raised when closed plus open cycles have elapsed.
- R11: Each time new settings arrive in the timeout domain the count restarts. While disabled, the watchdog never raises `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| wd_clk | input | 1 | Slow timeout clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| unlock | input | 1 | Change-protection unlock; writes are ignored while low |
| wr_en | input | 1 | Register write strobe (bus clock) |
| addr | input | 2 | Register address: 0 control, 1 window, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback of the addressed register |
| refresh | input | 1 | One-cycle refresh pulse (bus clock) |
| rst_req | output | 1 | Reset request, one timeout-clock cycle wide |

## Verification
The bench sets BASE_CYC to 8, so the five valid period codes span 8 to 128 timeout-clock cycles. This makes the longest period and the reserved-code clamp reachable in about a thousand bus cycles. The short codes also bring the one-cycle minimum within reach; at that length `rst_req` is raised on every timeout-clock cycle. The timeout clock runs at one eighth of the bus rate with its edges placed between bus edges. This lets the cycle-accurate reference model predict exactly where each handshake and each refresh lands.

// File: rtl/wwdt_core.sv
`timescale 1ns/1ps
module wwdt_core #(
  parameter int BASE_CYC = 500
) (
  input  logic       bus_clk,
  input  logic       wd_clk,
  input  logic       rst_n,
  input  logic       unlock,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       refresh,
  output logic       rst_req
);
  localparam int CW = $clog2(BASE_CYC * 32 + 1);

  logic       en_b, wen_b, req_t, kick_t, b1, b2;
  logic [3:0] per_b, wper_b;
  logic       c1, c2, c3, k1, k2, k3;
  logic       en_w, wen_w;
  logic [3:0] per_w, wper_w;
  logic [CW-1:0] cnt;

  wire busy   = req_t ^ b2;
  wire wr_ok  = wr_en & unlock & ~busy;
  wire wr_ctl = wr_ok && addr == 2'd0;
  wire wr_win = wr_ok && addr == 2'd1 && wdata[0];
  wire start  = (wr_ctl && (en_b || wdata[0])) || (wr_win && en_b);

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_b <= 1'b0; per_b <= '0; wen_b <= 1'b0; wper_b <= '0;
      req_t <= 1'b0; kick_t <= 1'b0; b1 <= 1'b0; b2 <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_b  <= wdata[0];
        per_b <= wdata[5:2];
      end
      if (wr_win) begin
        wen_b  <= wdata[1];
        wper_b <= wdata[5:2];
      end
      if (start)   req_t  <= ~req_t;
      if (refresh) kick_t <= ~kick_t;
      b1 <= c3;
      b2 <= b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {2'b00, per_b, 1'b0, en_b};
      2'd1:    rdata = {2'b00, wper_b, wen_b, 1'b0};
      2'd2:    rdata = {7'd0, busy};
      default: rdata = 8'd0;
    endcase
  end

  function automatic logic [CW-1:0] span(input logic [3:0] code);
    int v;
    if (code >= 4'd10)     v = BASE_CYC << 4;
    else if (code >= 4'd6) v = BASE_CYC << (code - 4'd6);
    else                   v = BASE_CYC >> (4'd6 - code);
    if (v == 0) v = 1;
    return CW'(v);
  endfunction

  wire [CW-1:0] closed_len = span(wper_w);
  wire [CW-1:0] open_len   = span(per_w);
  wire [CW-1:0] limit      = wen_w ? closed_len + open_len : open_len;
  wire          cap        = c2 ^ c3;
  wire          kick       = k2 ^ k3;

  always_ff @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= 1'b0; c2 <= 1'b0; c3 <= 1'b0;
      k1 <= 1'b0; k2 <= 1'b0; k3 <= 1'b0;
      en_w <= 1'b0; wen_w <= 1'b0; per_w <= '0; wper_w <= '0;
      cnt <= '0; rst_req <= 1'b0;
    end else begin
      c1 <= req_t; c2 <= c1; c3 <= c2;
      k1 <= kick_t; k2 <= k1; k3 <= k2;
      if (cap) begin
        en_w <= en_b; per_w <= per_b; wen_w <= wen_b; wper_w <= wper_b;
        cnt <= '0; rst_req <= 1'b0;
      end else if (!en_w) begin
        cnt <= '0; rst_req <= 1'b0;
      end else if (kick) begin
        rst_req <= wen_w && (cnt < closed_len);
        cnt     <= '0;
      end else if (cnt == limit - 1'b1) begin
        rst_req <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt     <= cnt + 1'b1;
        rst_req <= 1'b0;
      end
    end
  end
endmodule

module wwdt_core_chk (
  input logic       bus_clk,
  input logic       wd_clk,
  input logic       rst_n,
  input logic       unlock,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       en_b,
  input logic       wen_b,
  input logic [3:0] per_b,
  input logic [3:0] wper_b,
  input logic       en_w,
  input logic       rst_req
);
  // R6
  status_rsvd_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (addr == 2'd2) |-> (rdata[7:1] == 7'd0));
  // R5
  busy_src_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && unlock));
  // R7
  busy_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable({en_b, per_b, wen_b, wper_b}));
  // R3
  win_lock_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !wdata[0]) |=> $stable({wen_b, wper_b}));
  // R2
  locked_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && !unlock) |=> $stable({en_b, per_b, wen_b, wper_b}));
  // R11
  idle_quiet_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
    rst_req |-> en_w);
endmodule

bind wwdt_core wwdt_core_chk u_chk (
  .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n), .unlock(unlock),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
  .en_b(en_b), .wen_b(wen_b), .per_b(per_b), .wper_b(wper_b),
  .en_w(en_w), .rst_req(rst_req)
);

// File: tb/wwdt_core_bench.sv
`timescale 1ns/1ps
module wwdt_core_bench;
  localparam int BASE = 8;

  logic bus_clk = 1'b0, wd_clk = 1'b0, rst_n = 1'b0;
  logic unlock = 1'b0, wr_en = 1'b0, refresh = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic rst_req;

  wwdt_core #(.BASE_CYC(BASE)) u_wwdt_core (
    .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n), .unlock(unlock),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .refresh(refresh), .rst_req(rst_req));

  always #2.5 bus_clk = ~bus_clk;
  initial begin
    #5;
    forever begin wd_clk = 1'b1; #20; wd_clk = 1'b0; #20; end
  end

  int vecs = 0, errs = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  int m_en, m_per, m_wen, m_wper, m_busy, busy_cd;
  int w_en, w_per, w_wen, w_wper, w_cnt, m_rst;
  int cq[$];
  int rq[$];

  function automatic int span(int code);
    int v;
    if (code >= 10)     v = BASE * 16;
    else if (code >= 6) v = BASE * (1 << (code - 6));
    else                v = BASE / (1 << (6 - code));
    return (v < 1) ? 1 : v;
  endfunction

  always @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_wen = 0; m_wper = 0; m_busy = 0; busy_cd = -1;
      cq.delete(); rq.delete();
    end else begin
      int acc, sync;
      acc = wr_en && unlock && !m_busy;
      sync = 0;
      if (acc && addr == 2'd0) begin
        sync = m_en || wdata[0];
        m_en = wdata[0]; m_per = int'(wdata[5:2]);
      end
      if (acc && addr == 2'd1 && wdata[0]) begin
        sync = m_en;
        m_wen = wdata[1]; m_wper = int'(wdata[5:2]);
      end
      if (busy_cd > 0) begin
        busy_cd--;
        if (busy_cd == 0) begin m_busy = 0; busy_cd = -1; end
      end
      if (sync) begin m_busy = 1; cq.push_back(3); end
      if (refresh) rq.push_back(3);
    end
  end

  always @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      w_en = 0; w_per = 0; w_wen = 0; w_wper = 0; w_cnt = 0; m_rst = 0;
    end else begin
      int cap, kick, closed, lim;
      cap = 0; kick = 0;
      foreach (cq[i]) cq[i]--;
      foreach (rq[i]) rq[i]--;
      if (cq.size() > 0 && cq[0] == 0) begin void'(cq.pop_front()); cap = 1; end
      if (rq.size() > 0 && rq[0] == 0) begin void'(rq.pop_front()); kick = 1; end
      closed = span(w_wper);
      lim = w_wen ? closed + span(w_per) : span(w_per);
      if (cap) begin
        w_en = m_en; w_per = m_per; w_wen = m_wen; w_wper = m_wper;
        w_cnt = 0; m_rst = 0; busy_cd = 2;
      end else if (!w_en) begin
        w_cnt = 0; m_rst = 0;
      end else if (kick) begin
        m_rst = (w_wen && w_cnt < closed) ? 1 : 0;
        w_cnt = 0;
      end else if (w_cnt == lim - 1) begin
        m_rst = 1; w_cnt = 0;
      end else begin
        w_cnt++; m_rst = 0;
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {2'b00, 4'(m_per), 1'b0, 1'(m_en)};
      2'd1: return {2'b00, 4'(m_wper), 1'(m_wen), 1'b0};
      2'd2: return {7'd0, 1'(m_busy)};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge bus_clk) begin
    #1;
    if (!finished) begin
      logic [7:0] e;
      e = exp_rd(addr);
      vecs++;
      if (rdata !== e) begin
        errs++;
        $display("FAIL %s rdata addr=%0d got %h exp %h", tag, addr, rdata, e);
      end
      if (rst_req !== 1'(m_rst)) begin
        errs++;
        $display("FAIL %s rst_req got %b exp %0d", tag, rst_req, m_rst);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge bus_clk);
      wr_en = 1'b0; refresh = 1'b0; unlock = 1'b0;
      addr = addr + 2'd1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic u);
    @(negedge bus_clk);
    wr_en = 1'b1; addr = a; wdata = d; unlock = u; refresh = 1'b0;
    @(negedge bus_clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic kick();
    @(negedge bus_clk); refresh = 1'b1;
    @(negedge bus_clk); refresh = 1'b0;
  endtask

  initial begin
    tag = "R1";
    repeat (4) @(posedge bus_clk);
    #2 rst_n = 1'b1;
    idle(8);

    tag = "R2";
    wr(2'd0, 8'h19, 1'b0); idle(4);
    wr(2'd1, 8'h07, 1'b0); idle(4);

    tag = "R3";
    wr(2'd1, 8'h1A, 1'b1); idle(4);
    wr(2'd1, 8'h1B, 1'b1); idle(6);

    tag = "R6";
    wr(2'd2, 8'hFF, 1'b1); wr(2'd3, 8'hFF, 1'b1); idle(4);

    tag = "R4";
    wr(2'd0, 8'h19, 1'b1);
    tag = "R7";
    wr(2'd1, 8'h03, 1'b1); wr(2'd0, 8'h00, 1'b1);
    tag = "R5";
    idle(40);

    tag = "R10";
    idle(8); kick(); idle(60);
    kick(); idle(90);
    kick(); idle(300);

    tag = "R9";
    wr(2'd1, 8'h01, 1'b1); idle(40);
    for (int i = 0; i < 5; i++) begin kick(); idle(40); end
    idle(120);

    tag = "R8";
    wr(2'd0, 8'h3D, 1'b1); idle(1150);
    wr(2'd0, 8'h01, 1'b1); idle(80);
    wr(2'd0, 8'h0D, 1'b1); idle(80);

    tag = "R11";
    wr(2'd0, 8'h00, 1'b1); idle(40);
    kick(); idle(200);
    tag = "R5";
    wr(2'd1, 8'h03, 1'b1); idle(10);
    wr(2'd0, 8'h08, 1'b1); idle(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      errs++;
      $display("FAIL watchdog expired in %s got hang exp completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule